// File: doc/BRIEF.md
# QAM16 Error Vector Magnitude Meter

This block measures how far a stream of demodulated sixteen-point quadrature samples sits from its ideal constellation. Each accepted I/Q pair is paired with an ideal point. That point comes either from a built-in nearest-level decision on each axis or, when the external-reference control is high, from a pair of reference inputs supplied alongside the sample. The block keeps two running sums over a programmed number of symbols: the squared distance between sample and ideal point, and the squared length of the ideal point.

Once the last symbol has been taken, a restoring divider forms the ratio of the two sums, already scaled to percent squared with fixed-point fraction bits. A bit-serial square-root engine then turns that ratio into an EVM percentage. The result stays on the output, together with a done flag, until the next start pulse.

Samples arrive on a valid/ready stream. The block raises `s_ready` only while a run still needs symbols. A pair is taken on a rising clock edge where both `s_valid` and `s_ready` are high. A source may hold `s_valid` high for as long as it likes, and nothing is taken while `s_ready` is low. The block never needs to stall in the middle of a run, so `s_ready` stays high until the programmed count has been reached.

Top module: `evm_meter`

## Requirements
- R1: After reset, `done`, `s_ready` and `ref_zero` are 0, and `err_sum`, `ref_sum` and `evm_pct` are 0.
- R2: With `cfg_ref_en` low, each axis value x is mapped, with u = `cfg_step`, as follows: x < -2u gives -3u; -2u <= x < 0 gives -u; 0 <= x < 2u gives +u; x >= 2u gives +3u. So a value of exactly 0 maps to +u, exactly 2u maps to +3u, and exactly -2u maps to -u.
- R3: With `cfg_ref_en` high, the ideal point is (`s_ref_i`, `s_ref_q`) for that symbol, and the built-in decision is not used.
- R4: Each accepted symbol adds (I-I0)^2+(Q-Q0)^2 to `err_sum` and I0^2+Q0^2 to `ref_sum`, where (I0,Q0) is the ideal point.
- R5: `s_ready` is high only during a run that still has symbols left. A pair with `s_valid` low, or one offered while `s_ready` is low, leaves both sums unchanged.
- R6: A `start` pulse clears both sums, `done`, `ref_zero` and `evm_pct`, and loads `cfg_sym_count`. It takes effect in any state. A count of 0 goes straight to the result stage.
- R7: The result is `evm_pct` = floor(sqrt(floor(10000 * 2^(2*FRAC) * err_sum / ref_sum))), which is the EVM in percent with FRAC fraction bits. If that value exceeds 2^OW-1, the output saturates to all ones.
- R8: `done` rises once the result is valid. It then stays high with `evm_pct` unchanged until the next `start`.
- R9: If `ref_sum` is 0 at the end of a run, `ref_zero` goes to 1, `evm_pct` is all ones, and `done` is raised. Otherwise `ref_zero` is 0.
- R10: A run of 2^SYM_LOG symbols at the largest possible error and reference magnitudes does not overflow either sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new run (one-cycle pulse) |
| cfg_sym_count | input | CNTW | Number of symbols in the run |
| cfg_step | input | DW-1 | Unit step u of the ideal levels |
| cfg_ref_en | input | 1 | Use the external ideal point instead of the decision |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Block can take a sample pair |
| s_i | input | DW | In-phase sample, signed |
| s_q | input | DW | Quadrature sample, signed |
| s_ref_i | input | DW | External ideal in-phase value, signed |
| s_ref_q | input | DW | External ideal quadrature value, signed |
| err_sum | output | 2*DW+4+SYM_LOG | Sum of squared error lengths |
| ref_sum | output | 2*DW+4+SYM_LOG | Sum of squared ideal lengths |
| evm_pct | output | OW | EVM percent, unsigned, FRAC fraction bits |
| done | output | 1 | Result valid |
| ref_zero | output | 1 | Reference sum was zero; result saturated |

## Verification
The bench builds the block with DW=8, FRAC=4, OW=12 and SYM_LOG=16. The narrow 12-bit result makes both saturation paths easy to reach with a single symbol: the zero reference sum and the overflowing ratio. The 8-bit samples keep a full 2^16-symbol run at the largest error inside the cycle budget, so the width of the sums is tested exactly rather than by argument. The short divider that these widths give also lets many separate runs fit. Among them are the exact-tie decision values, gaps in `s_valid`, and a restart in the middle of a run.

// File: rtl/evm_pkg.sv
package evm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_PREP,
    ST_DIV,
    ST_ROOT,
    ST_DONE
  } evm_state_t;

  // percent squared: 100^2
  localparam int unsigned PCT_SQ   = 10000;
  localparam int unsigned PCT_SQ_W = 14;
endpackage

// File: rtl/evm_slicer.sv
module evm_slicer #(
  parameter int DW = 12,
  parameter int LW = DW + 2
) (
  input  logic signed [DW-1:0] x,
  input  logic        [DW-2:0] step,
  output logic signed [LW-1:0] lvl
);
  logic signed [LW-1:0] xs, u1, u2, u3;

  always_comb begin
    xs = x;
    u1 = $signed({3'b000, step});
    u2 = u1 <<< 1;
    u3 = u1 + u2;
    if (xs < -u2)      lvl = -u3;
    else if (xs < 0)   lvl = -u1;
    else if (xs < u2)  lvl = u1;
    else               lvl = u3;
  end
endmodule

// File: rtl/evm_accum.sv
module evm_accum #(
  parameter int DW   = 12,
  parameter int LW   = DW + 2,
  parameter int ACCW = 44
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] xi,
  input  logic signed [DW-1:0] xq,
  input  logic signed [LW-1:0] ii,
  input  logic signed [LW-1:0] iq,
  output logic [ACCW-1:0]      err_sum,
  output logic [ACCW-1:0]      ref_sum
);
  localparam int EW = LW + 1;

  logic signed [EW-1:0]   xi_e, xq_e, ii_e, iq_e, di, dq;
  logic signed [2*EW-1:0] pdi, pdq;
  logic signed [2*LW-1:0] pri, prq;
  logic [ACCW-1:0]        err_term, ref_term;

  always_comb begin
    xi_e = xi;
    xq_e = xq;
    ii_e = ii;
    iq_e = iq;
    di   = xi_e - ii_e;
    dq   = xq_e - iq_e;
    pdi  = di * di;
    pdq  = dq * dq;
    pri  = ii * ii;
    prq  = iq * iq;
    err_term = ACCW'({1'b0, pdi}) + ACCW'({1'b0, pdq});
    ref_term = ACCW'({1'b0, pri}) + ACCW'({1'b0, prq});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_sum <= '0;
      ref_sum <= '0;
    end else if (clr) begin
      err_sum <= '0;
      ref_sum <= '0;
    end else if (en) begin
      err_sum <= err_sum + err_term;
      ref_sum <= ref_sum + ref_term;
    end
  end
endmodule

// File: rtl/evm_divider.sv
module evm_divider #(
  parameter int NW  = 74,
  parameter int DNW = 44,
  parameter int QW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [NW-1:0]  num,
  input  logic [DNW-1:0] den,
  output logic           fin,
  output logic [QW-1:0]  quo
);
  localparam int CW = $clog2(NW + 1);

  logic           busy, ovf, ge;
  logic [CW-1:0]  cnt;
  logic [NW-1:0]  nsh;
  logic [DNW-1:0] rem, den_q, rem_nx;
  logic [QW-1:0]  qsh;
  logic [DNW:0]   trial, diff;

  always_comb begin
    trial  = {rem, nsh[NW-1]};
    ge     = trial >= {1'b0, den_q};
    diff   = trial - {1'b0, den_q};
    rem_nx = ge ? diff[DNW-1:0] : trial[DNW-1:0];
    quo    = ovf ? '1 : qsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ovf   <= 1'b0;
      fin   <= 1'b0;
      cnt   <= '0;
      nsh   <= '0;
      rem   <= '0;
      den_q <= '0;
      qsh   <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        ovf   <= 1'b0;
        cnt   <= '0;
        nsh   <= num;
        rem   <= '0;
        den_q <= den;
        qsh   <= '0;
      end else if (busy) begin
        nsh <= nsh << 1;
        rem <= rem_nx;
        qsh <= {qsh[QW-2:0], ge};
        ovf <= ovf | qsh[QW-1];
        cnt <= cnt + 1'b1;
        if (cnt == CW'(NW - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evm_isqrt.sv
module evm_isqrt #(
  parameter int OW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [2*OW-1:0] rad,
  output logic            fin,
  output logic [OW-1:0]   root
);
  logic            busy;
  logic [2*OW-1:0] rad_q, sq;
  logic [OW-1:0]   bit_q, trial;

  always_comb begin
    trial = root | bit_q;
    sq    = {{OW{1'b0}}, trial} * {{OW{1'b0}}, trial};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      rad_q <= '0;
      root  <= '0;
      bit_q <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        rad_q <= rad;
        root  <= '0;
        bit_q <= {1'b1, {(OW-1){1'b0}}};
      end else if (busy) begin
        if (sq <= rad_q) root <= trial;
        bit_q <= bit_q >> 1;
        if (bit_q[0]) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evm_meter.sv
module evm_meter #(
  parameter int DW      = 12,
  parameter int SYM_LOG = 16,
  parameter int CNTW    = 17,
  parameter int FRAC    = 8,
  parameter int OW      = 16,
  localparam int ACCW   = 2*DW + 4 + SYM_LOG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNTW-1:0]      cfg_sym_count,
  input  logic [DW-2:0]        cfg_step,
  input  logic                 cfg_ref_en,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [DW-1:0] s_q,
  input  logic signed [DW-1:0] s_ref_i,
  input  logic signed [DW-1:0] s_ref_q,
  output logic [ACCW-1:0]      err_sum,
  output logic [ACCW-1:0]      ref_sum,
  output logic [OW-1:0]        evm_pct,
  output logic                 done,
  output logic                 ref_zero
);
  import evm_pkg::*;

  localparam int LW = DW + 2;
  localparam int QW = 2 * OW;
  localparam int NW = ACCW + PCT_SQ_W + 2*FRAC;

  evm_state_t           state;
  logic [CNTW-1:0]      remain;
  logic                 accept, div_go, div_fin, root_go, root_fin;
  logic [NW-1:0]        num_w;
  logic [QW-1:0]        quo;
  logic [OW-1:0]        root;
  logic signed [DW-1:0] smp [2];
  logic signed [DW-1:0] rsm [2];
  logic signed [LW-1:0] lvl [2];
  logic signed [LW-1:0] ideal [2];

  assign smp[0] = s_i;
  assign smp[1] = s_q;
  assign rsm[0] = s_ref_i;
  assign rsm[1] = s_ref_q;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    evm_slicer #(.DW(DW), .LW(LW)) u_slc (
      .x    (smp[a]),
      .step (cfg_step),
      .lvl  (lvl[a])
    );
    always_comb begin
      if (cfg_ref_en) ideal[a] = LW'(rsm[a]);
      else            ideal[a] = lvl[a];
    end
  end

  assign s_ready = (state == ST_RUN) && (remain != '0);
  assign accept  = s_valid && s_ready;
  assign done    = (state == ST_DONE);
  assign div_go  = (state == ST_PREP) && (ref_sum != '0);
  assign root_go = (state == ST_DIV) && div_fin;
  assign num_w   = (NW'(err_sum) * NW'(PCT_SQ)) << (2*FRAC);

  evm_accum #(.DW(DW), .LW(LW), .ACCW(ACCW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .en      (accept),
    .xi      (s_i),
    .xq      (s_q),
    .ii      (ideal[0]),
    .iq      (ideal[1]),
    .err_sum (err_sum),
    .ref_sum (ref_sum)
  );

  evm_divider #(.NW(NW), .DNW(ACCW), .QW(QW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (num_w),
    .den   (ref_sum),
    .fin   (div_fin),
    .quo   (quo)
  );

  evm_isqrt #(.OW(OW)) u_sqrt (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (root_go),
    .rad   (quo),
    .fin   (root_fin),
    .root  (root)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain   <= '0;
      evm_pct  <= '0;
      ref_zero <= 1'b0;
    end else if (start) begin
      state    <= ST_RUN;
      remain   <= cfg_sym_count;
      evm_pct  <= '0;
      ref_zero <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (accept) remain <= remain - 1'b1;
          if (remain == '0) state <= ST_PREP;
        end
        ST_PREP: begin
          if (ref_sum == '0) begin
            ref_zero <= 1'b1;
            evm_pct  <= '1;
            state    <= ST_DONE;
          end else begin
            state <= ST_DIV;
          end
        end
        ST_DIV:  if (div_fin) state <= ST_ROOT;
        ST_ROOT: begin
          if (root_fin) begin
            evm_pct <= root;
            state   <= ST_DONE;
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/evm_meter_checker.sv
module evm_meter_checker #(
  parameter int ACCW = 44,
  parameter int OW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            s_valid,
  input logic            s_ready,
  input logic [ACCW-1:0] err_sum,
  input logic [ACCW-1:0] ref_sum,
  input logic [OW-1:0]   evm_pct,
  input logic            done,
  input logic            ref_zero
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !start) |=> (err_sum >= $past(err_sum)) && (ref_sum >= $past(ref_sum))); // R10
  AST_NOT_READY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s_valid && s_ready) && !start) |=> ($stable(err_sum) && $stable(ref_sum))); // R5
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (err_sum == '0) && (ref_sum == '0) && !done && !ref_zero); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(evm_pct))); // R8
  AST_ZERO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ref_zero) |-> (evm_pct == '1)); // R9
  AST_ZERO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ref_sum != '0)) |-> !ref_zero); // R9
endmodule

bind evm_meter evm_meter_checker #(.ACCW(ACCW), .OW(OW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .err_sum  (err_sum),
  .ref_sum  (ref_sum),
  .evm_pct  (evm_pct),
  .done     (done),
  .ref_zero (ref_zero)
);

// File: tb/evm_meter_bench.sv
`timescale 1ns/1ps
module evm_meter_bench;
  localparam int DW = 8, SYM_LOG = 16, CNTW = 17, FRAC = 4, OW = 12;
  localparam int ACCW = 2*DW + 4 + SYM_LOG;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cfg_ref_en = 1'b0, s_valid = 1'b0;
  logic [CNTW-1:0] cfg_sym_count = '0;
  logic [DW-2:0] cfg_step = '0;
  logic signed [DW-1:0] s_i = '0, s_q = '0, s_ref_i = '0, s_ref_q = '0;
  logic s_ready, done, ref_zero;
  logic [ACCW-1:0] err_sum, ref_sum;
  logic [OW-1:0] evm_pct;

  int n_tests = 0, n_fail = 0;
  longint e_m = 0, r_m = 0;
  int u = 20;

  always #5 clk = ~clk;

  evm_meter #(.DW(DW), .SYM_LOG(SYM_LOG), .CNTW(CNTW), .FRAC(FRAC), .OW(OW)) u_evm_meter (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_sym_count(cfg_sym_count),
    .cfg_step(cfg_step), .cfg_ref_en(cfg_ref_en), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .s_ref_i(s_ref_i), .s_ref_q(s_ref_q),
    .err_sum(err_sum), .ref_sum(ref_sum), .evm_pct(evm_pct), .done(done), .ref_zero(ref_zero));

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int slice_lvl(int x, int st);
    if (x < -2*st) return -3*st;
    else if (x < 0) return -st;
    else if (x < 2*st) return st;
    else return 3*st;
  endfunction

  function automatic logic [OW-1:0] exp_evm(longint e, longint r);
    logic [127:0] q;
    longint k;
    if (r == 0) return '1;
    q = ((128'(e) * 128'(10000)) << (2*FRAC)) / 128'(r);
    if (q >= (128'(1) << (2*OW))) return '1;
    k = 0;
    while ((k+1)*(k+1) <= longint'(q)) k++;
    return OW'(k);
  endfunction

  task automatic begin_run(input int n);
    start = 1'b1;
    cfg_sym_count = CNTW'(n);
    cfg_step = (DW-1)'(u);
    @(negedge clk);
    start = 1'b0;
    e_m = 0;
    r_m = 0;
  endtask

  task automatic send(input int xi, input int xq, input int ri, input int rq);
    longint i0, q0;
    s_i = DW'(xi); s_q = DW'(xq); s_ref_i = DW'(ri); s_ref_q = DW'(rq);
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    i0 = cfg_ref_en ? ri : slice_lvl(xi, u);
    q0 = cfg_ref_en ? rq : slice_lvl(xq, u);
    e_m += (xi - i0)*(xi - i0) + (xq - q0)*(xq - q0);
    r_m += i0*i0 + q0*q0;
  endtask

  task automatic wait_done(input string req);
    int c = 0;
    while (!done && c < 2000) begin
      @(negedge clk);
      c++;
    end
    chk(req, "done raised", done, 1);
  endtask

  task automatic check_result(input string tag);
    wait_done("R8");
    chk("R4", {tag, " err_sum"}, err_sum, e_m);
    chk("R4", {tag, " ref_sum"}, ref_sum, r_m);
    chk("R7", {tag, " evm_pct"}, evm_pct, exp_evm(e_m, r_m));
    chk("R9", {tag, " ref_zero"}, ref_zero, (r_m == 0));
  endtask

  task automatic t_reset();
    chk("R1", "done", done, 0);
    chk("R1", "s_ready", s_ready, 0);
    chk("R1", "ref_zero", ref_zero, 0);
    chk("R1", "err_sum", err_sum, 0);
    chk("R1", "ref_sum", ref_sum, 0);
    chk("R1", "evm_pct", evm_pct, 0);
  endtask

  task automatic t_exact();
    cfg_ref_en = 1'b0;
    begin_run(16);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        send((2*a-3)*u, (2*b-3)*u, 0, 0);
    check_result("exact R2");
    chk("R7", "exact zero evm", evm_pct, 0);
  endtask

  task automatic t_noisy();
    cfg_ref_en = 1'b0;
    begin_run(6);
    send(23, -58, 0, 0);
    send(-17, 41, 0, 0);
    send(65, -22, 0, 0);
    send(-61, 18, 0, 0);
    send(1, -39, 0, 0);
    send(127, -128, 0, 0);
    check_result("noisy R2");
  endtask

  task automatic t_ties();
    cfg_ref_en = 1'b0;
    begin_run(1);
    send(0, 2*u, 0, 0);
    wait_done("R2");
    chk("R2", "tie 0->+u, 2u->+3u err", err_sum, u*u + u*u);
    chk("R2", "tie ref", ref_sum, u*u + 9*u*u);
    begin_run(1);
    send(-2*u, -2*u-1, 0, 0);
    wait_done("R2");
    chk("R2", "tie -2u->-u, below->-3u err", err_sum, u*u + (u-1)*(u-1));
    chk("R2", "tie ref neg", ref_sum, u*u + 9*u*u);
  endtask

  task automatic t_ref_ext();
    cfg_ref_en = 1'b1;
    begin_run(3);
    send(10, -10, 7, -9);
    send(-50, 33, -45, 35);
    send(100, 100, 90, 80);
    check_result("ext R3");
    cfg_ref_en = 1'b0;
  endtask

  task automatic t_gaps();
    logic [ACCW-1:0] es;
    cfg_ref_en = 1'b0;
    begin_run(3);
    send(25, 25, 0, 0);
    es = err_sum;
    s_i = 8'sd100; s_q = -8'sd100;
    repeat (5) @(negedge clk);
    chk("R5", "valid low ignored", err_sum, es);
    chk("R5", "valid low ready", s_ready, 1);
    send(-5, 3, 0, 0);
    send(44, -70, 0, 0);
    check_result("gaps R5");
    es = err_sum;
    s_valid = 1'b1; s_i = 8'sd99; s_q = 8'sd99;
    repeat (3) @(negedge clk);
    chk("R5", "not ready after run", s_ready, 0);
    chk("R5", "offer after run ignored", err_sum, es);
    chk("R8", "done held", done, 1);
    s_valid = 1'b0;
  endtask

  task automatic t_zero_ref();
    cfg_ref_en = 1'b1;
    begin_run(2);
    send(5, -3, 0, 0);
    send(0, 0, 0, 0);
    wait_done("R9");
    chk("R9", "ref_zero set", ref_zero, 1);
    chk("R9", "evm saturated", evm_pct, {OW{1'b1}});
    chk("R4", "err_sum zero ref", err_sum, 34);
    cfg_ref_en = 1'b0;
  endtask

  task automatic t_sat();
    cfg_ref_en = 1'b1;
    begin_run(1);
    send(127, 127, 1, 0);
    wait_done("R7");
    chk("R7", "ratio saturates", evm_pct, {OW{1'b1}});
    chk("R9", "no zero flag", ref_zero, 0);
    cfg_ref_en = 1'b0;
  endtask

  task automatic t_count_zero();
    begin_run(0);
    wait_done("R6");
    chk("R6", "count 0 zero flag", ref_zero, 1);
    chk("R6", "count 0 evm", evm_pct, {OW{1'b1}});
  endtask

  task automatic t_restart();
    cfg_ref_en = 1'b0;
    begin_run(5);
    send(33, 33, 0, 0);
    send(-70, 9, 0, 0);
    begin_run(1);
    chk("R6", "restart err clear", err_sum, 0);
    chk("R6", "restart ref clear", ref_sum, 0);
    chk("R6", "restart done low", done, 0);
    chk("R6", "restart ready", s_ready, 1);
    send(12, -31, 0, 0);
    check_result("restart R6");
  endtask

  task automatic t_fullscale();
    cfg_ref_en = 1'b1;
    begin_run(65536);
    for (int k = 0; k < 65536; k++) send(-128, -128, 127, 127);
    check_result("full scale R10");
    chk("R10", "full scale err", err_sum, 64'd130050 * 64'd65536);
    cfg_ref_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_noisy();
    t_ties();
    t_ref_ext();
    t_gaps();
    t_zero_ref();
    t_sat();
    t_count_zero();
    t_restart();
    t_fullscale();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule